// File: doc/BRIEF.md
# Effective Address Unit with Indirection

This unit turns the operand fields of a memory-reference instruction into the final memory address. It adds the 20-bit address field of the instruction to an index register. That register is chosen by a 3-bit selector, and selector value zero stands for a constant zero. This one rule covers both the direct and the indexed cases with the same add step. When the indirection flag of the instruction is set, the unit then issues exactly one memory read at the indexed address. The word that comes back becomes the final address, unchanged.

A pulse on `start` makes the unit capture the instruction word. In the next cycle it reads the index register through a combinational register-read port. It then either finishes at once or waits on a request/valid memory handshake. A one-cycle `done` pulse marks the cycle in which `ea_out` holds the result. `ea_out` keeps that value until the next operation completes.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, `done`, `mem_req` and `rf_rd_en` are 0 and `ea_out` is 0.
- R2: For a non-indirect instruction (bit 26 = 0), `done` is high in the second cycle after the cycle in which `start` is sampled high.
- R3: An index selector (instruction bits 22..20) of 000 adds zero, whatever the register port returns. The address is then bits 19..0, zero-extended to 32 bits.
- R4: A nonzero index selector gives an address equal to the zero-extended bits 19..0 plus the selected register word, modulo 2^32.
- R5: In exactly the cycle after `start` is sampled, `rf_rd_en` is 1 and `rf_sel` equals instruction bits 22..20.
- R6: With bit 26 = 1, the unit issues one read whose `mem_addr` is the indexed address (indexing before indirection). The returned `mem_data` becomes `ea_out` unmodified, and `done` pulses in the cycle after `mem_valid` is sampled.
- R7: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` stays unchanged in the next cycle.
- R8: `start` is ignored while an operation is in progress. It neither restarts nor queues an operation.
- R9: `done` is high for exactly one cycle per operation. `ea_out` holds its value until the next completion.
- R10: An indirect instruction with index selector 000 reads memory at the zero-extended address field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation using `instr` |
| instr | input | 32 | Instruction word |
| rf_rd_en | output | 1 | Register read strobe |
| rf_sel | output | 3 | Register read selector |
| rf_data | input | 32 | Register word, combinational response to `rf_sel` |
| mem_req | output | 1 | Indirection read request |
| mem_addr | output | 32 | Indirection read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 32 | Read data word |
| ea_out | output | 32 | Final effective address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by the assertions on every cycle. These are the one-cycle width of `done`, and that the request and its address stay held until `mem_valid` arrives. They also cover the register strobe in the cycle after an accepted start, and the rule that a request only falls on completion. The add with wraparound, the zero substitution for selector 000, and pre-indexing before the indirect read need the bench. It compares every result against a reference computed from its own register and memory models, across random and directed instructions. That the unit ignores `start` while busy is only visible through the bench's mid-operation pulses.

// File: rtl/eau_pkg.sv
package eau_pkg;
   typedef enum logic [1:0] {
      EA_IDLE  = 2'd0,
      EA_INDEX = 2'd1,
      EA_WAIT  = 2'd2,
      EA_DONE  = 2'd3
   } ea_state_t;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 20,
   parameter int SEL_W   = 3
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [SEL_W-1:0]   sel,
   input  logic [DATA_W-1:0]  reg_val,
   output logic [DATA_W-1:0]  sum
);
   localparam int PAD_W = DATA_W - FIELD_W;

   logic [DATA_W-1:0] field_ext;
   logic [DATA_W-1:0] idx_val;

   generate
      if (FIELD_W > DATA_W) begin : g_bad
         $error("ea_index_add: FIELD_W exceeds DATA_W");
      end else if (PAD_W == 0) begin : g_full
         assign field_ext = field;
      end else begin : g_pad
         assign field_ext = {{PAD_W{1'b0}}, field};
      end
   endgenerate

   // selector zero is a constant zero register
   assign idx_val = (sel == '0) ? '0 : reg_val;
   assign sum     = field_ext + idx_val;

   // R3: zero selector never disturbs bits above the field
   always_comb begin
      if (sel == '0) begin
         a_r3_zero_index : assert (sum == field_ext);
      end
   end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import eau_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 20,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] field_in,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic               ind_in,
   input  logic [DATA_W-1:0]  sum,
   input  logic               mem_valid,
   input  logic [DATA_W-1:0]  mem_data,
   output logic [FIELD_W-1:0] cap_field,
   output logic [SEL_W-1:0]   cap_sel,
   output logic               rf_rd_en,
   output logic               mem_req,
   output logic [DATA_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  ea_out,
   output logic               done
);
   ea_state_t state;
   logic      cap_ind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= EA_IDLE;
         cap_field <= '0;
         cap_sel   <= '0;
         cap_ind   <= 1'b0;
         mem_addr  <= '0;
         ea_out    <= '0;
      end else begin
         unique case (state)
            EA_IDLE: begin
               if (start) begin
                  cap_field <= field_in;
                  cap_sel   <= sel_in;
                  cap_ind   <= ind_in;
                  state     <= EA_INDEX;
               end
            end
            EA_INDEX: begin
               if (cap_ind) begin
                  mem_addr <= sum;
                  state    <= EA_WAIT;
               end else begin
                  ea_out <= sum;
                  state  <= EA_DONE;
               end
            end
            EA_WAIT: begin
               if (mem_valid) begin
                  ea_out <= mem_data;
                  state  <= EA_DONE;
               end
            end
            default: state <= EA_IDLE;
         endcase
      end
   end

   assign rf_rd_en = (state == EA_INDEX);
   assign mem_req  = (state == EA_WAIT);
   assign done     = (state == EA_DONE);

   a_r9_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_req_held : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
   a_r5_read_after_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!rf_rd_en && !mem_req && !done && start) |=> rf_rd_en);
   a_r6_req_ends_done : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> done);
   a_r8_busy_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done) |=> !rf_rd_en);
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
   parameter int DATA_W  = 32,
   parameter int FIELD_W = 20,
   parameter int SEL_W   = 3,
   parameter int SEL_LSB = 20,
   parameter int IND_BIT = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] instr,
   output logic              rf_rd_en,
   output logic [SEL_W-1:0]  rf_sel,
   input  logic [DATA_W-1:0] rf_data,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data,
   output logic [DATA_W-1:0] ea_out,
   output logic              done
);
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   generate
      if (SEL_LSB < FIELD_W) begin : g_chk_overlap
         $error("eff_addr_unit: selector overlaps address field");
      end
      if (SEL_MSB >= IND_BIT) begin : g_chk_ind
         $error("eff_addr_unit: selector overlaps indirection bit");
      end
      if (IND_BIT >= DATA_W) begin : g_chk_width
         $error("eff_addr_unit: indirection bit outside word");
      end
   endgenerate

   logic [FIELD_W-1:0] cap_field;
   logic [DATA_W-1:0]  sum;
   logic               unused_instr;

   assign unused_instr = ^instr;

   ea_index_add #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_add (
      .field   (cap_field),
      .sel     (rf_sel),
      .reg_val (rf_data),
      .sum     (sum)
   );

   ea_seq #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .field_in  (instr[FIELD_W-1:0]),
      .sel_in    (instr[SEL_MSB:SEL_LSB]),
      .ind_in    (instr[IND_BIT]),
      .sum       (sum),
      .mem_valid (mem_valid),
      .mem_data  (mem_data),
      .cap_field (cap_field),
      .cap_sel   (rf_sel),
      .rf_rd_en  (rf_rd_en),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .ea_out    (ea_out),
      .done      (done)
   );
endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic        rf_rd_en;
   logic [2:0]  rf_sel;
   logic [31:0] rf_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_data = '0;
   logic [31:0] ea_out;
   logic        done;

   logic [31:0] regs [8];
   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign rf_data = regs[rf_sel];

   eff_addr_unit u_eff_addr_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .rf_rd_en(rf_rd_en), .rf_sel(rf_sel), .rf_data(rf_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_data(mem_data), .ea_out(ea_out), .done(done)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E3779B9) ^ 32'h5A5A0001;
   endfunction

   function automatic logic [31:0] idx_addr(input logic [31:0] ins);
      logic [2:0] s = ins[22:20];
      return {12'b0, ins[19:0]} + ((s == 3'd0) ? 32'd0 : regs[s]);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one operation; lat = cycles before mem_valid, poke = pulse start while busy
   task automatic run_op(input logic [31:0] ins, input int lat, input bit poke);
      logic [31:0] ia = idx_addr(ins);
      logic [31:0] fin;
      @(negedge clk);
      instr = ins; start = 1'b1;
      @(negedge clk);
      start = 1'b0; instr = $urandom;
      chk("R5 rd_en", {31'b0, rf_rd_en}, 32'd1);
      chk("R5 sel", {29'b0, rf_sel}, {29'b0, ins[22:20]});
      if (poke) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!ins[26]) begin
         fin = ia;
         chk("R2 done", {31'b0, done}, 32'd1);
         chk(ins[22:20] == 3'd0 ? "R3 addr" : "R4 addr", ea_out, fin);
      end else begin
         chk("R6 req", {31'b0, mem_req}, 32'd1);
         chk(ins[22:20] == 3'd0 ? "R10 rd_addr" : "R6 rd_addr", mem_addr, ia);
         for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R7 req held", {31'b0, mem_req}, 32'd1);
            chk("R7 addr held", mem_addr, ia);
         end
         fin = mem_word(ia);
         mem_valid = 1'b1; mem_data = fin;
         @(negedge clk);
         mem_valid = 1'b0; mem_data = $urandom;
         chk("R6 done", {31'b0, done}, 32'd1);
         chk("R6 final", ea_out, fin);
         chk("R6 single req", {31'b0, mem_req}, 32'd0);
      end
      @(negedge clk);
      chk("R9 done low", {31'b0, done}, 32'd0);
      chk("R9 hold", ea_out, fin);
      if (poke) chk("R8 no restart", {31'b0, rf_rd_en}, 32'd0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) regs[i] = $urandom;
      regs[0] = 32'hDEADBEEF;
      regs[1] = 32'hFFFFFFF0;
      repeat (3) @(negedge clk);
      chk("R1 done", {31'b0, done}, 32'd0);
      chk("R1 req", {31'b0, mem_req}, 32'd0);
      chk("R1 rd_en", {31'b0, rf_rd_en}, 32'd0);
      chk("R1 ea", ea_out, 32'd0);
      rst_n = 1'b1;
      // directed corners
      run_op({5'b01100, 1'b0, 3'd2, 3'd0, 20'hFFFFF}, 0, 1'b0); // R3 max field
      run_op({5'b01100, 1'b0, 3'd0, 3'd1, 20'h00020}, 0, 1'b0); // R4 wrap
      run_op({5'b01101, 1'b1, 3'd0, 3'd0, 20'h12345}, 2, 1'b0); // R10
      run_op({5'b01100, 1'b1, 3'd5, 3'd1, 20'h00030}, 0, 1'b0); // R6 wrap, no wait
      run_op({5'b01100, 1'b0, 3'd0, 3'd7, 20'h00001}, 0, 1'b1); // R8 direct
      run_op({5'b01110, 1'b1, 3'd0, 3'd3, 20'hABCDE}, 3, 1'b1); // R8 indirect
      for (int n = 0; n < 60; n++) begin
         logic [31:0] r = $urandom;
         run_op(r, int'($urandom % 5), r[31] & r[30]);
      end
      finish_run();
   end
endmodule